// File: doc/BRIEF.md
# Transmit Descriptor Chain Walker

This block is the control engine of a transmit DMA. Frames waiting to go out are described by four-word records in memory (control flags, buffer start address, status with frame length, link to the next record). Software writes the starting record address, sets the transmit enable level and pulses the kick input. The engine then reads each record through a request/acknowledge word port. It gives the buffer address and length to the frame sender and waits until the sender reports the frame done. It then writes back the completion status and returns the record to software by clearing its ownership bit.

The walk follows each record's link pointer, not a fixed ring. It ends at the first record that software still owns. In that case the engine raises a one-cycle descriptor-unavailable pulse and its current-record pointer stays on that record. A later kick fetches the same record again. A kick that arrives while the engine is busy is remembered, which makes the engine read the stopping record once more before it gives up. Clearing the enable lets the frame in flight finish, write-back included, and the engine then goes idle.

Top module: `txd_chain_walker`

## Requirements
- R1: After a synchronous active-low reset, mem_req, frm_valid and all three event pulses are low and cur_desc is 0.
- R2: A kick while tx_enable is low starts no memory access. A list_load pulse while idle copies list_base into cur_desc.
- R3: With tx_enable high, a kick starts a walk that reads the record at cur_desc word by word, in this order: flags (+0), buffer address (+4), status/length (+8), next pointer (+12).
- R4: For a record whose flags bit 31 is 1, frm_valid rises with frm_addr equal to the buffer word and frm_len equal to status bits 15:0. Both stay steady until frm_done, and no memory access takes place while frm_valid is high.
- R5: After frm_done the engine writes the status word (+8) with bit 19 set, bit 16 also set when flags bit 2 is 1, and every other bit kept. It then writes the flags word (+0) with bit 31 cleared and every other bit kept.
- R6: Each completed frame gives a one-cycle txcp_pulse. txintr_pulse goes high in the same cycle only when that record's flags bit 2 is 1.
- R7: After the flags write-back, cur_desc takes the record's next pointer, and with tx_enable high the walk goes on from there.
- R8: A flags word with bit 31 equal to 0 ends the walk after that single read. tdu_pulse goes high for one cycle and cur_desc keeps that record's address.
- R9: A kick while stopped fetches the record at cur_desc again.
- R10: A kick that arrives while a walk is in progress causes exactly one extra flags read of the stopping record, and tdu_pulse fires only after that second read.
- R11: If tx_enable falls during a frame, that frame finishes with both write-backs, cur_desc advances, and no further access follows.
- R12: Once mem_req is high, it stays high with address, write flag and write data unchanged until mem_ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_enable | input | 1 | Transmit enable level |
| poll_kick | input | 1 | One-cycle poll-demand pulse |
| list_load | input | 1 | Load list_base into the current pointer (idle only) |
| list_base | input | 32 | Start address of the record chain |
| mem_req | output | 1 | Memory word access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access complete; read data valid |
| mem_rdata | input | 32 | Read data |
| frm_valid | output | 1 | Frame handed to the sender |
| frm_addr | output | 32 | Frame buffer start address |
| frm_len | output | LEN_W | Frame length in bytes |
| frm_done | input | 1 | Sender finished the frame |
| cur_desc | output | 32 | Current record address |
| txcp_pulse | output | 1 | Frame complete event |
| txintr_pulse | output | 1 | Per-record interrupt event |
| tdu_pulse | output | 1 | Descriptor unavailable event |

## Verification
The checker checks on every cycle that memory requests and frame hand-offs hold steady until they are acknowledged. It also checks that writes go only to the flags or status word of the current record, that nothing touches memory during a frame, that the event pulses last one cycle and relate to each other correctly, and that a disabled idle engine stays quiet. Only the bench scenarios can show the exact order of addresses, the write-back values, where the chain is followed and where it stops, the refetch on a kick while stopped, the single extra fetch after a kick while busy, and the drain after the enable falls mid-frame.

// File: rtl/txd_pkg.sv
// Shared definitions for the transmit descriptor chain walker.
// Assumes 32-bit memory words and byte addressing (word = 4 bytes).
package txd_pkg;
    localparam int WORD_W   = 32;
    localparam int OWN_BIT  = 31;   // flags: 1 = engine owns the record
    localparam int IEN_BIT  = 2;    // flags: per-record interrupt enable
    localparam int CP_BIT   = 19;   // status: frame complete
    localparam int INT_BIT  = 16;   // status: interrupt raised
    localparam int IDX_W    = 2;    // word index inside a record

    localparam logic [IDX_W-1:0] W_FLAGS = 2'd0;
    localparam logic [IDX_W-1:0] W_BUF   = 2'd1;
    localparam logic [IDX_W-1:0] W_STAT  = 2'd2;
    localparam logic [IDX_W-1:0] W_NEXT  = 2'd3;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RD_FLAGS,
        ST_RD_BUF,
        ST_RD_STAT,
        ST_RD_NEXT,
        ST_SEND,
        ST_WR_STAT,
        ST_WR_FLAGS
    } walk_state_t;
endpackage

// File: rtl/txd_kick_tracker.sv
// Remembers one poll-demand kick that arrives while a walk is running.
// Assumes: start and consume are single-cycle strobes from the walker.
module txd_kick_tracker (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_enable,
    input  logic kick,
    input  logic busy,
    input  logic start,
    input  logic consume,
    output logic pending
);
    // Pending flag: set by a kick during a walk, cleared when used or disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
        end else if (!tx_enable) begin
            pending <= 1'b0;
        end else if (start || consume) begin
            pending <= 1'b0;
        end else if (kick && busy) begin
            pending <= 1'b1;
        end
    end
endmodule

// File: rtl/txd_wb_merge.sv
// Builds the two write-back words of a finished record.
// Assumes flags and status hold the values read from that record.
module txd_wb_merge
    import txd_pkg::*;
(
    input  logic [WORD_W-1:0] flags_in,
    input  logic [WORD_W-1:0] stat_in,
    output logic [WORD_W-1:0] flags_wb,
    output logic [WORD_W-1:0] stat_wb
);
    localparam logic [WORD_W-1:0] CP_MASK  = WORD_W'(1) << CP_BIT;
    localparam logic [WORD_W-1:0] INT_MASK = WORD_W'(1) << INT_BIT;
    localparam logic [WORD_W-1:0] OWN_MASK = WORD_W'(1) << OWN_BIT;

    // Status gets completion, plus interrupt when the record asks for it.
    always_comb begin
        stat_wb = stat_in | CP_MASK;
        if (flags_in[IEN_BIT]) begin
            stat_wb = stat_wb | INT_MASK;
        end
    end

    // Flags keep every bit except ownership, which returns to software.
    always_comb begin
        flags_wb = flags_in & ~OWN_MASK;
    end
endmodule

// File: rtl/txd_walk_fsm.sv
// Sequencer that reads records, hands off frames, writes back and follows links.
// Assumes a memory port that may take any number of cycles to acknowledge,
// and a frame sender that pulses frm_done once per frame.
module txd_walk_fsm
    import txd_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_enable,
    input  logic              kick,
    input  logic              pending,
    input  logic              list_load,
    input  logic [WORD_W-1:0] list_base,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              frm_done,
    input  logic [WORD_W-1:0] flags_wb,
    input  logic [WORD_W-1:0] stat_wb,
    output logic              busy,
    output logic              start,
    output logic              consume,
    output logic              mem_req,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic              frm_valid,
    output logic [WORD_W-1:0] frm_addr,
    output logic [LEN_W-1:0]  frm_len,
    output logic [WORD_W-1:0] cur_desc,
    output logic [WORD_W-1:0] flags_q,
    output logic [WORD_W-1:0] stat_q,
    output logic              txcp_pulse,
    output logic              txintr_pulse,
    output logic              tdu_pulse
);
    walk_state_t       state;
    logic [WORD_W-1:0] cur_q, buf_q, next_q;
    logic [IDX_W-1:0]  word_idx;

    // Strobes that the kick tracker needs.
    always_comb begin
        busy    = (state != ST_IDLE);
        start   = (state == ST_IDLE) && tx_enable && !list_load && (kick || pending);
        consume = (state == ST_RD_FLAGS) && mem_ack && !mem_rdata[OWN_BIT]
                  && pending && tx_enable;
    end

    // Main sequencer: state, captured record words, pointer and event pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= ST_IDLE;
            cur_q        <= '0;
            buf_q        <= '0;
            next_q       <= '0;
            flags_q      <= '0;
            stat_q       <= '0;
            txcp_pulse   <= 1'b0;
            txintr_pulse <= 1'b0;
            tdu_pulse    <= 1'b0;
        end else begin
            txcp_pulse   <= 1'b0;
            txintr_pulse <= 1'b0;
            tdu_pulse    <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (list_load) begin
                        cur_q <= list_base;
                    end else if (start) begin
                        state <= ST_RD_FLAGS;
                    end
                end
                ST_RD_FLAGS: begin
                    if (mem_ack) begin
                        flags_q <= mem_rdata;
                        if (mem_rdata[OWN_BIT]) begin
                            state <= ST_RD_BUF;
                        end else if (!consume) begin
                            tdu_pulse <= 1'b1;
                            state     <= ST_IDLE;
                        end
                    end
                end
                ST_RD_BUF: begin
                    if (mem_ack) begin
                        buf_q <= mem_rdata;
                        state <= ST_RD_STAT;
                    end
                end
                ST_RD_STAT: begin
                    if (mem_ack) begin
                        stat_q <= mem_rdata;
                        state  <= ST_RD_NEXT;
                    end
                end
                ST_RD_NEXT: begin
                    if (mem_ack) begin
                        next_q <= mem_rdata;
                        state  <= ST_SEND;
                    end
                end
                ST_SEND: begin
                    if (frm_done) begin
                        state <= ST_WR_STAT;
                    end
                end
                ST_WR_STAT: begin
                    if (mem_ack) begin
                        state <= ST_WR_FLAGS;
                    end
                end
                ST_WR_FLAGS: begin
                    if (mem_ack) begin
                        cur_q        <= next_q;
                        txcp_pulse   <= 1'b1;
                        txintr_pulse <= flags_q[IEN_BIT];
                        state        <= tx_enable ? ST_RD_FLAGS : ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Word index of the access the current state performs.
    always_comb begin
        case (state)
            ST_RD_BUF:   word_idx = W_BUF;
            ST_RD_STAT:  word_idx = W_STAT;
            ST_WR_STAT:  word_idx = W_STAT;
            ST_RD_NEXT:  word_idx = W_NEXT;
            default:     word_idx = W_FLAGS;
        endcase
    end

    // Memory port and frame hand-off driven from state.
    always_comb begin
        mem_req   = (state == ST_RD_FLAGS) || (state == ST_RD_BUF) ||
                    (state == ST_RD_STAT)  || (state == ST_RD_NEXT) ||
                    (state == ST_WR_STAT)  || (state == ST_WR_FLAGS);
        mem_we    = (state == ST_WR_STAT) || (state == ST_WR_FLAGS);
        mem_addr  = cur_q + {{(WORD_W-IDX_W-2){1'b0}}, word_idx, 2'b00};
        mem_wdata = (state == ST_WR_STAT) ? stat_wb : flags_wb;
        frm_valid = (state == ST_SEND);
        frm_addr  = buf_q;
        frm_len   = stat_q[LEN_W-1:0];
        cur_desc  = cur_q;
    end
endmodule

// File: rtl/txd_chain_walker.sv
// Top of the transmit descriptor chain walker: ties the sequencer, the
// write-back merge and the kick tracker together.
// Assumes one memory word port and one frame sender port.
module txd_chain_walker
    import txd_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_enable,
    input  logic              poll_kick,
    input  logic              list_load,
    input  logic [WORD_W-1:0] list_base,
    output logic              mem_req,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              frm_valid,
    output logic [WORD_W-1:0] frm_addr,
    output logic [LEN_W-1:0]  frm_len,
    input  logic              frm_done,
    output logic [WORD_W-1:0] cur_desc,
    output logic              txcp_pulse,
    output logic              txintr_pulse,
    output logic              tdu_pulse
);
    logic              busy, start, consume, pending;
    logic [WORD_W-1:0] flags_q, stat_q, flags_wb, stat_wb;

    txd_kick_tracker kick_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_enable (tx_enable),
        .kick      (poll_kick),
        .busy      (busy),
        .start     (start),
        .consume   (consume),
        .pending   (pending)
    );

    txd_wb_merge merge_i (
        .flags_in (flags_q),
        .stat_in  (stat_q),
        .flags_wb (flags_wb),
        .stat_wb  (stat_wb)
    );

    txd_walk_fsm #(.LEN_W(LEN_W)) fsm_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .tx_enable    (tx_enable),
        .kick         (poll_kick),
        .pending      (pending),
        .list_load    (list_load),
        .list_base    (list_base),
        .mem_ack      (mem_ack),
        .mem_rdata    (mem_rdata),
        .frm_done     (frm_done),
        .flags_wb     (flags_wb),
        .stat_wb      (stat_wb),
        .busy         (busy),
        .start        (start),
        .consume      (consume),
        .mem_req      (mem_req),
        .mem_we       (mem_we),
        .mem_addr     (mem_addr),
        .mem_wdata    (mem_wdata),
        .frm_valid    (frm_valid),
        .frm_addr     (frm_addr),
        .frm_len      (frm_len),
        .cur_desc     (cur_desc),
        .flags_q      (flags_q),
        .stat_q       (stat_q),
        .txcp_pulse   (txcp_pulse),
        .txintr_pulse (txintr_pulse),
        .tdu_pulse    (tdu_pulse)
    );
endmodule

// File: rtl/txd_chain_walker_chk.sv
// Port-level protocol checker for the transmit descriptor chain walker.
module txd_chain_walker_chk
    import txd_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tx_enable,
    input logic              mem_req,
    input logic              mem_we,
    input logic [WORD_W-1:0] mem_addr,
    input logic [WORD_W-1:0] mem_wdata,
    input logic              mem_ack,
    input logic              frm_valid,
    input logic [WORD_W-1:0] frm_addr,
    input logic [LEN_W-1:0]  frm_len,
    input logic              frm_done,
    input logic [WORD_W-1:0] cur_desc,
    input logic              txcp_pulse,
    input logic              txintr_pulse,
    input logic              tdu_pulse
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!mem_req && !frm_valid && !txcp_pulse && !txintr_pulse && !tdu_pulse));

    assert_disabled_stays_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_enable && !mem_req && !frm_valid) |=> !mem_req);

    assert_frame_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid && !frm_done) |=> (frm_valid && $stable(frm_addr) && $stable(frm_len)));

    assert_no_mem_in_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid |-> !mem_req);

    assert_write_target_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_addr == cur_desc || mem_addr == cur_desc + 32'd8));

    assert_txcp_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        txcp_pulse |=> !txcp_pulse);

    assert_txintr_with_txcp_R6: assert property (@(posedge clk) disable iff (!rst_n)
        txintr_pulse |-> txcp_pulse);

    assert_stop_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tdu_pulse |-> (!txcp_pulse && !frm_valid));

    assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                    && $stable(mem_wdata)));
endmodule

bind txd_chain_walker txd_chain_walker_chk #(.LEN_W(LEN_W)) chk_i (.*);

// File: tb/txd_chain_walker_tb_top.sv
// Scoreboard bench: driver tasks queue expected accesses and frames, the
// memory and frame-sink monitors pop and compare as the design acts.
module txd_chain_walker_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_enable = 1'b0;
    logic        poll_kick = 1'b0;
    logic        list_load = 1'b0;
    logic [31:0] list_base = '0;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        frm_valid;
    logic [31:0] frm_addr;
    logic [15:0] frm_len;
    logic        frm_done = 1'b0;
    logic [31:0] cur_desc;
    logic        txcp_pulse, txintr_pulse, tdu_pulse;

    always #2 clk = ~clk;   // 250 MHz

    txd_chain_walker dut_i (.*);

    typedef struct { bit we; logic [31:0] addr; logic [31:0] data; int req; } acc_t;
    typedef struct { logic [31:0] addr; logic [15:0] len; } frm_t;
    acc_t acc_q[$];
    frm_t frm_q[$];
    logic [31:0] mem [0:63];

    int n_chk = 0, n_bad = 0;
    int n_txcp = 0, n_txintr = 0, n_tdu = 0, n_acc = 0;
    int lat_cnt = 0, lat_sel = 0, f_cnt = 0, cyc = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Memory responder and access monitor (latency alternates 1 and 2).
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_ack = 1'b0; lat_cnt = 0;
        end else if (mem_ack) begin
            mem_ack = 1'b0; lat_cnt = 0;
        end else if (mem_req) begin
            lat_cnt++;
            if (lat_cnt > lat_sel) begin
                acc_t e;
                lat_sel = 1 - lat_sel;
                mem_ack = 1'b1;
                n_acc++;
                if (acc_q.size() == 0) begin
                    chk(1'b0, "R3", "unexpected access", mem_addr, 32'hFFFFFFFF);
                end else begin
                    e = acc_q.pop_front();
                    chk(mem_we == e.we && mem_addr == e.addr, $sformatf("R%0d", e.req),
                        "access address/dir", {mem_we, mem_addr[30:0]}, {e.we, e.addr[30:0]});
                    if (e.we)
                        chk(mem_wdata == e.data, $sformatf("R%0d", e.req), "write data",
                            mem_wdata, e.data);
                end
                if (mem_we) mem[mem_addr[7:2]] = mem_wdata;
                else        mem_rdata = mem[mem_addr[7:2]];
            end
        end
    end

    // Frame sink monitor and event counters.
    always @(negedge clk) begin
        if (rst_n) begin
            if (txcp_pulse)   n_txcp++;
            if (txintr_pulse) n_txintr++;
            if (tdu_pulse)    n_tdu++;
        end
        if (frm_done) begin
            frm_done = 1'b0;
        end else if (frm_valid) begin
            f_cnt++;
            if (f_cnt >= 3) begin
                frm_t e;
                f_cnt = 0;
                frm_done = 1'b1;
                if (frm_q.size() == 0) begin
                    chk(1'b0, "R4", "unexpected frame", frm_addr, 32'hFFFFFFFF);
                end else begin
                    e = frm_q.pop_front();
                    chk(frm_addr == e.addr && frm_len == e.len, "R4", "frame addr/len",
                        frm_addr ^ {16'd0, frm_len}, e.addr ^ {16'd0, e.len});
                end
            end
        end
    end

    // Watchdog: a hung run is a failure and still reaches the summary.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d expected < 150000 cycles", cyc);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic exp_rd(input logic [31:0] a, input int req);
        acc_q.push_back('{1'b0, a, 32'd0, req});
    endtask

    // Driver: queue the full expected handling of one engine-owned record.
    task automatic run_desc(input logic [31:0] a);
        logic [31:0] fl, bf, st, sw;
        fl = mem[a[7:2]]; bf = mem[a[7:2]+1]; st = mem[a[7:2]+2];
        exp_rd(a, 3); exp_rd(a + 4, 3); exp_rd(a + 8, 3); exp_rd(a + 12, 3);
        frm_q.push_back('{bf, st[15:0]});
        sw = st | 32'h0008_0000 | (fl[2] ? 32'h0001_0000 : 32'h0);
        acc_q.push_back('{1'b1, a + 8, sw, 5});
        acc_q.push_back('{1'b1, a, fl & 32'h7FFF_FFFF, 5});
    endtask

    task automatic set_desc(input logic [31:0] a, input logic [31:0] fl,
                            input logic [31:0] bf, input logic [31:0] st,
                            input logic [31:0] nx);
        mem[a[7:2]] = fl; mem[a[7:2]+1] = bf; mem[a[7:2]+2] = st; mem[a[7:2]+3] = nx;
    endtask

    task automatic kick();
        @(negedge clk); poll_kick = 1'b1;
        @(negedge clk); poll_kick = 1'b0;
    endtask

    task automatic wait_idle();
        while (acc_q.size() != 0 || frm_q.size() != 0) @(negedge clk);
        repeat (12) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 32'h0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!mem_req && !frm_valid, "R1", "req/valid after reset", {mem_req, frm_valid}, 0);
        chk(cur_desc == 0, "R1", "cur_desc after reset", cur_desc, 0);
        chk(!txcp_pulse && !txintr_pulse && !tdu_pulse, "R1", "pulses after reset",
            {txcp_pulse, txintr_pulse, tdu_pulse}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        set_desc(32'h10, 32'h8000_0004, 32'h1000, 32'h0000_0006, 32'h40);
        set_desc(32'h40, 32'h8000_0000, 32'h2000, 32'h0000_0012, 32'h20);

        // R2: load start address, kick while disabled does nothing
        list_base = 32'h10; list_load = 1'b1;
        @(negedge clk); list_load = 1'b0;
        kick();
        repeat (10) @(negedge clk);
        chk(n_acc == 0, "R2", "accesses while disabled", n_acc, 0);
        chk(cur_desc == 32'h10, "R2", "cur_desc after load", cur_desc, 32'h10);

        // R3 R5 R6 R7 R8: two-record chain ending on a software-owned record
        tx_enable = 1'b1;
        run_desc(32'h10); run_desc(32'h40); exp_rd(32'h20, 8);
        kick(); wait_idle();
        chk(cur_desc == 32'h20, "R7", "cur_desc at chain stop", cur_desc, 32'h20);
        chk(n_txcp == 2, "R6", "txcp count", n_txcp, 2);
        chk(n_txintr == 1, "R6", "txintr count", n_txintr, 1);
        chk(n_tdu == 1, "R8", "tdu count", n_tdu, 1);
        chk(mem[4] == 32'h0000_0004, "R5", "flags owner cleared A", mem[4], 32'h4);

        // R9: handed back record now owned by engine, kick refetches at cur_desc
        set_desc(32'h20, 32'h8000_0004, 32'h3000, 32'h0000_0003, 32'h60);
        run_desc(32'h20); exp_rd(32'h60, 8);
        kick(); wait_idle();
        chk(cur_desc == 32'h60, "R8", "cur_desc stays on stop record", cur_desc, 32'h60);
        exp_rd(32'h60, 9);
        kick(); wait_idle();
        chk(n_tdu == 3, "R9", "tdu after plain refetch", n_tdu, 3);
        chk(cur_desc == 32'h60, "R9", "cur_desc after refetch", cur_desc, 32'h60);

        // R10: kick during busy gives one extra fetch of the stop record
        set_desc(32'h60, 32'h8000_0000, 32'h4000, 32'h0000_0040, 32'h90);
        run_desc(32'h60); exp_rd(32'h90, 10); exp_rd(32'h90, 10);
        kick();
        while (!frm_valid) @(negedge clk);
        kick();
        wait_idle();
        chk(n_tdu == 4, "R10", "single tdu after extra fetch", n_tdu, 4);
        chk(cur_desc == 32'h90, "R10", "cur_desc after extra fetch", cur_desc, 32'h90);

        // R11: disable mid-frame, frame drains, walk stops on next pointer
        set_desc(32'h90, 32'h8000_0004, 32'h5000, 32'h0000_0005, 32'hA0);
        set_desc(32'hA0, 32'h8000_0000, 32'h6000, 32'h0000_0007, 32'h20);
        run_desc(32'h90);
        kick();
        while (!frm_valid) @(negedge clk);
        tx_enable = 1'b0;
        wait_idle();
        chk(cur_desc == 32'hA0, "R11", "cur_desc after drain", cur_desc, 32'hA0);
        chk(n_txcp == 5, "R11", "txcp after drain", n_txcp, 5);
        chk(mem[38] == 32'h0009_0005, "R11", "status of drained frame", mem[38], 32'h0009_0005);
        tx_enable = 1'b1;
        run_desc(32'hA0); exp_rd(32'h20, 7);
        kick(); wait_idle();
        chk(n_txcp == 6 && n_txintr == 3, "R6", "final txcp/txintr",
            {n_txcp[15:0], n_txintr[15:0]}, {16'd6, 16'd3});
        chk(n_tdu == 5 && cur_desc == 32'h20, "R7", "final stop",
            cur_desc, 32'h20);
        // R12 is watched on every cycle by the bound checker.

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule